// File: doc/BRIEF.md
# Shift and Rotate Unit with Flag Update

This block performs a single shift or rotate on an 8-, 16- or 32-bit operand. A 3-bit operation digit selects one of four rotates (plain left, plain right, left through carry, right through carry) or one of the shifts (logical left, logical right, arithmetic right). A count input sets the distance, and only its low five bits are used. Along with the result, the block returns updated carry and overflow flags. Shifts also return updated sign, zero and parity flags.

The caller presents the operand, the size, the count and the incoming flag values, and pulses `start` for one cycle. Exactly one cycle later the registered result and flags appear with `valid`. A new request may be issued in every cycle. A small controller with two states sequences the block. `ST_IDLE` moves to `ST_DONE` on `start` (transition "accept"). `ST_DONE` stays in `ST_DONE` on another `start` (transition "chain"). `ST_DONE` returns to `ST_IDLE` when no `start` arrives (transition "retire"). `valid` is high only in `ST_DONE`.

Top module: `sru_top`

## Requirements
- R1: `valid` is high in the cycle after each cycle in which `start` is high, and low in every other cycle, including during reset.
- R2: The operation digit `op` selects the operation: 0 rotate left, 1 rotate right, 2 rotate left through carry, 3 rotate right through carry, 4 and 6 logical left shift, 5 logical right shift, 7 arithmetic right shift. The `size` input selects the operand width: 0 is 8 bits, 1 is 16 bits, 2 or 3 is 32 bits. Result bits above the selected width are always zero.
- R3: Only `count[4:0]` is used; `count[7:5]` has no effect.
- R4: Plain rotates move the bit that leaves one end into the other end and copy it into CF. After a left rotate, CF equals the result's bit 0. After a right rotate, CF equals the result's top bit.
- R5: The carry-through rotates treat CF and the operand as one ring of width+1 bits. For example, an 8-bit rotate by 9 returns both the operand and CF unchanged.
- R6: A left shift fills with zeros from bit 0, and CF receives the last bit shifted out. A count greater than the width gives a zero result with CF = 0.
- R7: A logical right shift fills with zeros from the top. An arithmetic right shift fills with copies of the sign bit. In both cases CF receives the last bit shifted out.
- R8: When the masked count is 1, OF is set as follows. For a left shift or left rotate, OF = new CF xor the result's top bit. For a right rotate, OF = the xor of the result's two top bits. For a logical right shift, OF = the operand's original top bit. For an arithmetic right shift, OF = 0.
- R9: When the masked count is greater than 1, OF keeps its incoming value.
- R10: When the masked count is zero, the result equals the operand truncated to the selected width, and all five flags keep their incoming values.
- R11: After a shift with a nonzero masked count, SF is the result's top bit and ZF is 1 when the result is zero. PF is 1 when bits [7:0] of the result hold an even number of ones.
- R12: Rotates keep the incoming SF, ZF and PF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe; inputs are captured on this cycle |
| op | input | 3 | Operation digit |
| size | input | 2 | Operand width select |
| operand | input | 32 | Value to shift or rotate |
| count | input | 8 | Shift distance; only the low five bits are used |
| cf_in | input | 1 | Incoming carry flag |
| of_in | input | 1 | Incoming overflow flag |
| sf_in | input | 1 | Incoming sign flag |
| zf_in | input | 1 | Incoming zero flag |
| pf_in | input | 1 | Incoming parity flag |
| valid | output | 1 | Result and flags are valid |
| result | output | 32 | Shifted or rotated value |
| cf_out | output | 1 | Updated carry flag |
| of_out | output | 1 | Updated overflow flag |
| sf_out | output | 1 | Updated sign flag |
| zf_out | output | 1 | Updated zero flag |
| pf_out | output | 1 | Updated parity flag |

## Verification
Every result and every flag is due exactly one clock after its `start`. Requests are issued on falling edges, and each one pushes its expected item into a queue when it is issued. On each falling edge where `valid` is high, a monitor pops exactly one item and compares it. A `valid` with no pending item, or an item that never gets popped, means a result came early, came late or went missing. An idle gap checks that `valid` drops one cycle after `start` stops.

// File: rtl/sru_pkg.sv
package sru_pkg;
    localparam int DATA_W  = 32;
    localparam int CNT_W   = 5;
    localparam int CNT_IN_W = 8;
    localparam int IDX_W   = $clog2(DATA_W);
    localparam int NSTEP   = (1 << CNT_W) - 1;

    typedef enum logic [2:0] {
        OP_ROL     = 3'd0,
        OP_ROR     = 3'd1,
        OP_RCL     = 3'd2,
        OP_RCR     = 3'd3,
        OP_SHL     = 3'd4,
        OP_SHR     = 3'd5,
        OP_SHL_ALT = 3'd6,
        OP_SAR     = 3'd7
    } sru_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_WORD2 = 2'd3
    } sru_size_e;

    typedef struct packed {
        logic cf;
        logic of;
        logic sf;
        logic zf;
        logic pf;
    } sru_flags_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } sru_state_e;
endpackage

// File: rtl/sru_core.sv
module sru_core
    import sru_pkg::*;
(
    input  sru_op_e              op,
    input  sru_size_e            size,
    input  logic [DATA_W-1:0]    operand,
    input  logic [CNT_W-1:0]     cnt,
    input  logic                 cf_in,
    output logic [DATA_W-1:0]    res,
    output logic                 cf_new,
    output logic [IDX_W-1:0]     hi,
    output logic                 orig_msb
);
    logic [DATA_W-1:0] wmask;
    logic [DATA_W-1:0] v;
    logic              c;
    logic              t;

    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                hi    = IDX_W'(7);
                wmask = DATA_W'(8'hFF);
            end
            SZ_HALF: begin
                hi    = IDX_W'(15);
                wmask = DATA_W'(16'hFFFF);
            end
            SZ_WORD, SZ_WORD2: begin
                hi    = IDX_W'(DATA_W - 1);
                wmask = '1;
            end
        endcase
    end

    assign orig_msb = operand[hi];

    always_comb begin
        v = operand & wmask;
        c = cf_in;
        t = 1'b0;
        for (int i = 0; i < NSTEP; i++) begin
            if (CNT_W'(i) < cnt) begin
                unique case (op)
                    OP_ROL: begin
                        c = v[hi];
                        v = ((v << 1) | DATA_W'(c)) & wmask;
                    end
                    OP_ROR: begin
                        c     = v[0];
                        v     = v >> 1;
                        v[hi] = c;
                    end
                    OP_RCL: begin
                        t = v[hi];
                        v = ((v << 1) | DATA_W'(c)) & wmask;
                        c = t;
                    end
                    OP_RCR: begin
                        t     = v[0];
                        v     = v >> 1;
                        v[hi] = c;
                        c     = t;
                    end
                    OP_SHL, OP_SHL_ALT: begin
                        c = v[hi];
                        v = (v << 1) & wmask;
                    end
                    OP_SHR: begin
                        c = v[0];
                        v = v >> 1;
                    end
                    OP_SAR: begin
                        t     = v[hi];
                        c     = v[0];
                        v     = v >> 1;
                        v[hi] = t;
                    end
                endcase
            end
        end
        res    = v;
        cf_new = c;
    end
endmodule

// File: rtl/sru_flags.sv
module sru_flags
    import sru_pkg::*;
(
    input  sru_op_e            op,
    input  logic [CNT_W-1:0]   cnt,
    input  logic [DATA_W-1:0]  res,
    input  logic [IDX_W-1:0]   hi,
    input  logic               cf_new,
    input  logic               orig_msb,
    input  sru_flags_t         fl_in,
    output sru_flags_t         fl_out
);
    logic is_shift;
    logic cnt_zero;
    logic cnt_one;
    logic top;
    logic next_top;
    logic of_one;

    assign is_shift = op[2];
    assign cnt_zero = (cnt == '0);
    assign cnt_one  = (cnt == CNT_W'(1));
    assign top      = res[hi];
    assign next_top = res[hi - IDX_W'(1)];

    always_comb begin
        unique case (op)
            OP_ROL, OP_RCL, OP_SHL, OP_SHL_ALT: of_one = cf_new ^ top;
            OP_ROR, OP_RCR:                     of_one = top ^ next_top;
            OP_SHR:                             of_one = orig_msb;
            OP_SAR:                             of_one = 1'b0;
        endcase
    end

    always_comb begin
        fl_out = fl_in;
        if (!cnt_zero) begin
            fl_out.cf = cf_new;
            if (cnt_one) begin
                fl_out.of = of_one;
            end
            if (is_shift) begin
                fl_out.sf = top;
                fl_out.zf = (res == '0);
                fl_out.pf = ~^res[7:0];
            end
        end
    end
endmodule

// File: rtl/sru_fsm.sv
module sru_fsm
    import sru_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic valid
);
    sru_state_e state_q;
    sru_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_DONE;
            ST_DONE: state_d = start ? ST_DONE : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        load  = start;
        valid = (state_q == ST_DONE);
    end
endmodule

// File: rtl/sru_top.sv
module sru_top
    import sru_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [2:0]  op,
    input  logic [1:0]  size,
    input  logic [31:0] operand,
    input  logic [7:0]  count,
    input  logic        cf_in,
    input  logic        of_in,
    input  logic        sf_in,
    input  logic        zf_in,
    input  logic        pf_in,
    output logic        valid,
    output logic [31:0] result,
    output logic        cf_out,
    output logic        of_out,
    output logic        sf_out,
    output logic        zf_out,
    output logic        pf_out
);
    logic [CNT_W-1:0]  cnt_m;
    logic              unused_cnt_hi;
    logic [DATA_W-1:0] res_c;
    logic              cf_c;
    logic [IDX_W-1:0]  hi_c;
    logic              msb_c;
    sru_flags_t        fl_in_c;
    sru_flags_t        fl_c;
    logic              load;
    logic [DATA_W-1:0] res_q;
    sru_flags_t        fl_q;

    assign cnt_m         = count[CNT_W-1:0];
    assign unused_cnt_hi = ^count[CNT_IN_W-1:CNT_W];
    assign fl_in_c       = '{cf: cf_in, of: of_in, sf: sf_in, zf: zf_in, pf: pf_in};

    sru_core core_i (
        .op       (sru_op_e'(op)),
        .size     (sru_size_e'(size)),
        .operand  (operand),
        .cnt      (cnt_m),
        .cf_in    (cf_in),
        .res      (res_c),
        .cf_new   (cf_c),
        .hi       (hi_c),
        .orig_msb (msb_c)
    );

    sru_flags flags_i (
        .op       (sru_op_e'(op)),
        .cnt      (cnt_m),
        .res      (res_c),
        .hi       (hi_c),
        .cf_new   (cf_c),
        .orig_msb (msb_c),
        .fl_in    (fl_in_c),
        .fl_out   (fl_c)
    );

    sru_fsm fsm_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .valid (valid)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            fl_q  <= '0;
        end else if (load) begin
            res_q <= res_c;
            fl_q  <= fl_c;
        end
    end

    assign result = res_q;
    assign cf_out = fl_q.cf;
    assign of_out = fl_q.of;
    assign sf_out = fl_q.sf;
    assign zf_out = fl_q.zf;
    assign pf_out = fl_q.pf;
endmodule

// File: rtl/sru_checker.sv
module sru_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [2:0]  op,
    input logic [1:0]  size,
    input logic [7:0]  count,
    input logic        cf_in,
    input logic        of_in,
    input logic        sf_in,
    input logic        zf_in,
    input logic        pf_in,
    input logic        valid,
    input logic [31:0] result,
    input logic        cf_out,
    input logic        of_out,
    input logic        sf_out,
    input logic        zf_out,
    input logic        pf_out
);
    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> valid);

    assert_valid_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !valid);

    assert_byte_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start && size == 2'd0 |=> result[31:8] == 24'd0);

    assert_half_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start && size == 2'd1 |=> result[31:16] == 16'd0);

    assert_zero_count_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start && count[4:0] == 5'd0 |=>
            cf_out == $past(cf_in) && of_out == $past(of_in) &&
            sf_out == $past(sf_in) && zf_out == $past(zf_in) && pf_out == $past(pf_in));

    assert_rotate_keeps_szp_R12: assert property (@(posedge clk) disable iff (!rst_n)
        start && !op[2] |=>
            sf_out == $past(sf_in) && zf_out == $past(zf_in) && pf_out == $past(pf_in));

    assert_sar_one_of_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start && op == 3'd7 && count[4:0] == 5'd1 |=> !of_out);

    assert_multi_count_of_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start && count[4:0] > 5'd1 |=> of_out == $past(of_in));
endmodule

bind sru_top sru_checker chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op      (op),
    .size    (size),
    .count   (count),
    .cf_in   (cf_in),
    .of_in   (of_in),
    .sf_in   (sf_in),
    .zf_in   (zf_in),
    .pf_in   (pf_in),
    .valid   (valid),
    .result  (result),
    .cf_out  (cf_out),
    .of_out  (of_out),
    .sf_out  (sf_out),
    .zf_out  (zf_out),
    .pf_out  (pf_out)
);

// File: tb/sru_top_tb_top.sv
module sru_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [1:0]  size = '0;
    logic [31:0] operand = '0;
    logic [7:0]  count = '0;
    logic        cf_in = 1'b0, of_in = 1'b0, sf_in = 1'b0, zf_in = 1'b0, pf_in = 1'b0;
    logic        valid;
    logic [31:0] result;
    logic        cf_out, of_out, sf_out, zf_out, pf_out;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [31:0] res;
        logic [4:0]  fl;
        string       tag;
    } exp_t;

    exp_t q[$];

    always #5 clk = ~clk;

    sru_top dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .size(size),
        .operand(operand), .count(count),
        .cf_in(cf_in), .of_in(of_in), .sf_in(sf_in), .zf_in(zf_in), .pf_in(pf_in),
        .valid(valid), .result(result),
        .cf_out(cf_out), .of_out(of_out), .sf_out(sf_out), .zf_out(zf_out), .pf_out(pf_out)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // fl packing: {cf, of, sf, zf, pf}
    function automatic exp_t model(input logic [2:0] o, input logic [1:0] sz,
                                   input logic [31:0] x_in, input logic [7:0] craw,
                                   input logic [4:0] fl);
        exp_t e;
        int w;
        int n;
        int k;
        longint unsigned m, mm, x, r, v, t;
        longint sx;
        logic cf, of, sf, zf, pf, msb;
        w  = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        m  = (64'd1 << w) - 1;
        mm = (64'd1 << (w + 1)) - 1;
        x  = longint'(x_in) & m;
        n  = int'(craw & 8'h1F);
        {cf, of, sf, zf, pf} = fl;
        r = x;
        if (n != 0) begin
            case (o)
                3'd0: begin
                    k = n % w;
                    if (k != 0) r = ((x << k) | (x >> (w - k))) & m;
                    cf = r[0];
                end
                3'd1: begin
                    k = n % w;
                    if (k != 0) r = ((x >> k) | (x << (w - k))) & m;
                    cf = r[w-1];
                end
                3'd2, 3'd3: begin
                    v = (longint'(fl[4]) << w) | x;
                    k = n % (w + 1);
                    if (k != 0) begin
                        if (o == 3'd2) v = ((v << k) | (v >> (w + 1 - k))) & mm;
                        else           v = ((v >> k) | (v << (w + 1 - k))) & mm;
                    end
                    r  = v & m;
                    cf = v[w];
                end
                3'd4, 3'd6: begin
                    t  = x << n;
                    cf = t[w];
                    r  = t & m;
                end
                3'd5: begin
                    t  = x >> (n - 1);
                    cf = t[0];
                    r  = x >> n;
                end
                default: begin
                    sx = x[w-1] ? longint'(x | ~m) : longint'(x);
                    r  = longint'(sx >>> n) & m;
                    t  = longint'(sx >>> (n - 1));
                    cf = t[0];
                end
            endcase
            msb = r[w-1];
            if (n == 1) begin
                case (o)
                    3'd1, 3'd3: of = r[w-1] ^ r[w-2];
                    3'd5:       of = x[w-1];
                    3'd7:       of = 1'b0;
                    default:    of = cf ^ msb;
                endcase
            end
            if (o[2]) begin
                sf = msb;
                zf = (r == 0);
                pf = ~^r[7:0];
            end
        end
        e.res = r[31:0];
        e.fl  = {cf, of, sf, zf, pf};
        e.tag = "";
        return e;
    endfunction

    task automatic drive(input logic [2:0] o, input logic [1:0] sz, input logic [31:0] x,
                         input logic [7:0] c, input logic [4:0] fl, input string tag);
        exp_t e;
        e = model(o, sz, x, c, fl);
        e.tag = tag;
        q.push_back(e);
        op = o; size = sz; operand = x; count = c;
        {cf_in, of_in, sf_in, zf_in, pf_in} = fl;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // monitor: results are due one cycle after start, checked on the falling edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (valid) begin
                if (q.size() == 0) begin
                    check("R1", "unexpected valid", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(e.tag, "result", result, e.res);
                    check(e.tag, "flags{cf,of,sf,zf,pf}",
                          {27'd0, cf_out, of_out, sf_out, zf_out, pf_out}, {27'd0, e.fl});
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "valid in reset", {31'd0, valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "valid after reset", {31'd0, valid}, 32'd0);
        check("R1", "result after reset", result, 32'd0);

        drive(3'd0, 2'd0, 32'h81, 8'd1, 5'b00000, "R4");
        drive(3'd1, 2'd1, 32'h0001, 8'd1, 5'b00000, "R4");
        drive(3'd0, 2'd0, 32'hA5, 8'd8, 5'b00000, "R4");
        drive(3'd2, 2'd0, 32'h80, 8'd1, 5'b00000, "R5");
        drive(3'd2, 2'd0, 32'h5A, 8'd9, 5'b10000, "R5");
        drive(3'd3, 2'd2, 32'h0000_0001, 8'd1, 5'b10000, "R5");
        drive(3'd3, 2'd1, 32'h1234, 8'd17, 5'b00000, "R5");
        drive(3'd4, 2'd0, 32'h40, 8'd1, 5'b00000, "R6");
        drive(3'd4, 2'd1, 32'hFFFF, 8'd17, 5'b10000, "R6");
        drive(3'd6, 2'd2, 32'h8000_0001, 8'd1, 5'b00000, "R6");
        drive(3'd5, 2'd0, 32'h80, 8'd1, 5'b00000, "R7");
        drive(3'd7, 2'd0, 32'h80, 8'd3, 5'b00000, "R7");
        drive(3'd7, 2'd1, 32'h8001, 8'd1, 5'b01000, "R8");
        drive(3'd1, 2'd0, 32'h01, 8'd1, 5'b00000, "R8");
        drive(3'd4, 2'd2, 32'h4000_0000, 8'd2, 5'b01000, "R9");
        drive(3'd0, 2'd0, 32'h3C, 8'd2, 5'b01000, "R9");
        drive(3'd0, 2'd2, 32'hDEAD_BEEF, 8'h21, 5'b00000, "R3");
        drive(3'd4, 2'd2, 32'hDEAD_BEEF, 8'h20, 5'b11111, "R3");
        drive(3'd5, 2'd0, 32'hFFFF_FF7E, 8'd0, 5'b10101, "R10");
        drive(3'd4, 2'd0, 32'h80, 8'd1, 5'b00100, "R11");
        drive(3'd5, 2'd1, 32'h0300, 8'd8, 5'b00000, "R11");
        drive(3'd0, 2'd1, 32'h0000, 8'd3, 5'b00111, "R12");
        drive(3'd3, 2'd0, 32'hFF, 8'd4, 5'b00101, "R12");
        drive(3'd1, 2'd0, 32'hFFFF_1234, 8'd4, 5'b00000, "R2");

        for (int i = 0; i < 400; i++) begin
            logic [31:0] rx;
            logic [7:0]  rc;
            logic [2:0]  ro;
            logic [1:0]  rs;
            logic [4:0]  rf;
            rx = $urandom;
            rc = 8'($urandom);
            ro = 3'($urandom);
            rs = 2'($urandom);
            rf = 5'($urandom);
            if (i % 3 == 0) rc = rc & 8'h03;
            drive(ro, rs, rx, rc, rf, "R2");
            if (i % 50 == 0) @(negedge clk);
        end

        @(negedge clk);
        check("R1", "valid after idle", {31'd0, valid}, 32'd0);
        check("R1", "pending items", q.size(), 32'd0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule